// File: doc/BRIEF.md
# Serial Receiver with Break Wake-Up

This block takes an asynchronous serial line and turns it into received words. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. The `nine_bit` control selects the frame length. Each bit is sampled in the middle of its bit time. The block counts 16 ticks of an external `baud_tick` strobe per bit. Finished words go into a two-entry buffer. Software reads that buffer through a read strobe. Each word carries its own framing-error flag. A full buffer that meets a third finished word reports an overrun.

For low-power operation the block has a wake-up mode, set by pulsing `wake_set`. In this mode the block receives no frames. It only watches the line for a high-to-low transition, such as the start of a break character. That edge raises the same receive interrupt that data uses. A read of the data port clears that interrupt. The mode switches itself off on the next low-to-high transition of the line, and normal reception then resumes.

Top module: `uart_wake_rx`

## Requirements
- R1: With `nine_bit`=0, a frame with a start bit, 8 data bits sent LSB first and a stop bit loads a word. In that word `rd_data[7:0]` holds the data and `rd_data[8]` is 0.
- R2: With `nine_bit`=1, the ninth received data bit appears on `rd_data[8]`.
- R3: `rd_ferr` is 1 for a word whose stop bit was sampled low, and 0 otherwise. The flag belongs to that word alone.
- R4: The buffer holds up to two words and returns them in arrival order. `rx_irq` is high while at least one word is unread. A pulse on `rd_strobe` removes the oldest word.
- R5: A word that finishes while both buffer entries are unread sets `overrun` and is dropped. While `overrun` is set, no further word is loaded.
- R6: Frames are received only while both `port_en` and `cont_rx` are 1. Driving `cont_rx` to 0 clears `overrun`.
- R7: While `wake_en` is 1, no word is loaded. A falling edge on `rx_in` sets `rx_irq`.
- R8: A `rd_strobe` pulse clears the interrupt raised by a wake-up event.
- R9: `wake_en` goes to 1 one cycle after a `wake_set` pulse. It returns to 0 on the first rising edge of the line after the wake-up event.
- R10: A start bit is accepted only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit loads no word.
- R11: After reset, `rx_irq`, `overrun` and `wake_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial input line (idle high) |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| port_en | input | 1 | Receiver enable |
| cont_rx | input | 1 | Continuous-receive enable; 0 clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| wake_set | input | 1 | Pulse that enters wake-up mode |
| rd_strobe | input | 1 | Read pulse; removes the oldest word and clears the wake interrupt |
| rd_data | output | 9 | Oldest unread data word |
| rd_ferr | output | 1 | Framing-error flag of the oldest unread word |
| rx_irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun flag |
| wake_en | output | 1 | Wake-up mode is active |

## Verification
The hardest state to reach is overrun followed by its recovery. The bench sends three full frames with no read in between, so the third word meets a full buffer. It then reads the two stored words back in order and sends a fourth frame while overrun is still set, which must not load. Only after that does it drop `cont_rx`. The wake-up path is driven with a long low break followed by a return to high. This proves that the break loaded no framed word, and that the interrupt survives the automatic exit from wake-up mode until a read clears it.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

    localparam int OSR      = 16;
    localparam int MID_TICK = OSR / 2 - 1;
    localparam int CW       = $clog2(OSR);
    localparam int WW       = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [WW-1:0] data;
        logic          ferr;
    } rx_word_t;

    function automatic logic [WW-1:0] align_word(input logic [WW-1:0] sh, input logic nine);
        return nine ? sh : {1'b0, sh[WW-1:1]};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic rx_fall,
    output logic rx_rise
);
    logic [2:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= 3'b111;
        else     sr <= {sr[1:0], rx_in};
    end

    assign rx_s    = sr[1];
    assign rx_fall = sr[2] & ~sr[1];
    assign rx_rise = ~sr[2] & sr[1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     tick,
    input  logic     nine_bit,
    input  logic     rx_s,
    input  logic     rx_fall,
    output logic     word_vld,
    output rx_word_t word_out
);
    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [WW-1:0] shreg;
    logic [3:0]    last_bit;

    assign last_bit = nine_bit ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            word_vld <= 1'b0;
            word_out <= '0;
        end else begin
            word_vld <= 1'b0;
            if (!active) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (rx_fall) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                    ST_START: if (tick) begin
                        if (cnt == CW'(MID_TICK)) begin
                            cnt   <= '0;
                            bidx  <= '0;
                            state <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CW'(OSR - 1)) begin
                            shreg <= {rx_s, shreg[WW-1:1]};
                            if (bidx == last_bit) state <= ST_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end
                    end
                    ST_STOP: if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CW'(OSR - 1)) begin
                            word_vld      <= 1'b1;
                            word_out.data <= align_word(shreg, nine_bit);
                            word_out.ferr <= ~rx_s;
                            state         <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
    import uart_wake_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_word_t din,
    input  logic     pop,
    input  logic     ovr_clr,
    output rx_word_t head,
    output logic     not_empty,
    output logic     full,
    output logic     overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_word_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [NW-1:0] count;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (count != '0);
    assign full      = (count == NW'(DEPTH));
    assign do_pop    = pop & not_empty;
    assign do_push   = push & ~overrun & ~full;
    assign head      = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            overrun <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            count <= count + NW'(do_push) - NW'(do_pop);
            if (ovr_clr)                      overrun <= 1'b0;
            else if (push & full & ~overrun)  overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_wake.sv
module rx_wake (
    input  logic clk,
    input  logic rst,
    input  logic wake_set,
    input  logic rx_fall,
    input  logic rx_rise,
    input  logic rd_strobe,
    output logic wake_en,
    output logic wake_irq
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_en  <= 1'b0;
            seen     <= 1'b0;
            wake_irq <= 1'b0;
        end else begin
            if (wake_set) begin
                wake_en <= 1'b1;
                seen    <= 1'b0;
            end else if (wake_en && rx_fall) begin
                seen <= 1'b1;
            end else if (wake_en && seen && rx_rise) begin
                wake_en <= 1'b0;
                seen    <= 1'b0;
            end
            if (wake_en && rx_fall && !wake_set) wake_irq <= 1'b1;
            else if (rd_strobe)                  wake_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_in,
    input  logic          baud_tick,
    input  logic          port_en,
    input  logic          cont_rx,
    input  logic          nine_bit,
    input  logic          wake_set,
    input  logic          rd_strobe,
    output logic [WW-1:0] rd_data,
    output logic          rd_ferr,
    output logic          rx_irq,
    output logic          overrun,
    output logic          wake_en
);
    logic     rx_s, rx_fall, rx_rise;
    logic     push, full, not_empty, wake_irq;
    rx_word_t word, head;

    rx_line_sync u_sync (
        .clk(clk), .rst(rst), .rx_in(rx_in),
        .rx_s(rx_s), .rx_fall(rx_fall), .rx_rise(rx_rise)
    );

    rx_frame u_frame (
        .clk(clk), .rst(rst),
        .active(port_en & cont_rx & ~wake_en),
        .tick(baud_tick), .nine_bit(nine_bit),
        .rx_s(rx_s), .rx_fall(rx_fall),
        .word_vld(push), .word_out(word)
    );

    rx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(push), .din(word),
        .pop(rd_strobe), .ovr_clr(~cont_rx),
        .head(head), .not_empty(not_empty), .full(full), .overrun(overrun)
    );

    rx_wake u_wake (
        .clk(clk), .rst(rst), .wake_set(wake_set),
        .rx_fall(rx_fall), .rx_rise(rx_rise), .rd_strobe(rd_strobe),
        .wake_en(wake_en), .wake_irq(wake_irq)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;
    assign rx_irq  = not_empty | wake_irq;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
    input logic clk,
    input logic rst,
    input logic rx_s,
    input logic rx_rise,
    input logic wake_set,
    input logic wake_en,
    input logic push,
    input logic full,
    input logic cont_rx,
    input logic overrun,
    input logic rx_irq
);
    // R7: falling line edge in wake-up mode raises the interrupt
    p_wake_irq_r7: assert property (@(posedge clk) disable iff (rst)
        wake_en && $fell(rx_s) && !wake_set |=> rx_irq);

    // R7: no framed word is produced while wake-up mode has been active
    p_wake_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        wake_en && $past(wake_en) |-> !push);

    // R5: a word meeting a full buffer sets overrun
    p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
        push && full && cont_rx |=> overrun);

    // R5: overrun persists while continuous receive stays on
    p_ovr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        overrun && cont_rx |=> overrun);

    // R6: dropping continuous receive clears overrun
    p_ovr_clr_r6: assert property (@(posedge clk) disable iff (rst)
        !cont_rx |=> !overrun);

    // R9: wake-up mode exits only after a rising line edge
    p_wake_exit_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_en) |-> $past(rx_rise));
endmodule

bind uart_wake_rx uart_wake_rx_chk chk_i (
    .clk(clk), .rst(rst), .rx_s(rx_s), .rx_rise(rx_rise),
    .wake_set(wake_set), .wake_en(wake_en), .push(push), .full(full),
    .cont_rx(cont_rx), .overrun(overrun), .rx_irq(rx_irq)
);

// File: tb/uart_wake_rx_tb_top.sv
`timescale 1ns/1ps
module uart_wake_rx_tb_top;
    localparam int TDIV = 3;
    localparam int BITC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       baud_tick;
    logic       port_en = 1'b1;
    logic       cont_rx = 1'b1;
    logic       nine_bit = 1'b0;
    logic       wake_set = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rd_data;
    logic       rd_ferr, rx_irq, overrun, wake_en;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tdc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdc <= (tdc == TDIV - 1) ? 0 : tdc + 1;
        cyc <= cyc + 1;
    end
    assign baud_tick = (tdc == 0);

    uart_wake_rx dut_i (
        .clk(clk), .rst(rst), .rx_in(rx_in), .baud_tick(baud_tick),
        .port_en(port_en), .cont_rx(cont_rx), .nine_bit(nine_bit),
        .wake_set(wake_set), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_ferr(rd_ferr), .rx_irq(rx_irq), .overrun(overrun), .wake_en(wake_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [8:0] exp_word(input logic [8:0] d, input logic nine);
        return nine ? d : {1'b0, d[7:0]};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input logic nine, input logic stop);
        rx_in = 1'b0; idle(BITC);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_in = d[i]; idle(BITC);
        end
        rx_in = stop; idle(BITC);
        rx_in = 1'b1; idle(BITC);
    endtask

    task automatic read_chk(input string req, input logic [8:0] d, input logic fe);
        chk(req, {31'd0, rx_irq}, 32'd1);
        chk(req, {23'd0, rd_data}, {23'd0, d});
        chk(req, {31'd0, rd_ferr}, {31'd0, fe});
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] d1, d2, d3;
        logic nb, sb;
        void'($urandom(32'h5eed_0042));
        idle(5);
        rst = 1'b0;
        idle(2);
        // R11 reset state
        chk("R11", {31'd0, rx_irq}, 32'd0);
        chk("R11", {31'd0, overrun}, 32'd0);
        chk("R11", {31'd0, wake_en}, 32'd0);

        // R1 directed 8-bit frame
        nine_bit = 1'b0;
        send(9'h0A5, 1'b0, 1'b1);
        read_chk("R1", 9'h0A5, 1'b0);
        // R2 directed 9-bit frame with bit 8 set
        nine_bit = 1'b1;
        send(9'h13C, 1'b1, 1'b1);
        read_chk("R2", 9'h13C, 1'b0);
        // R3 framing error then a clean word: flag stays with each word (R4 order)
        nine_bit = 1'b0;
        send(9'h055, 1'b0, 1'b0);
        send(9'h0C3, 1'b0, 1'b1);
        read_chk("R3", 9'h055, 1'b1);
        read_chk("R4", 9'h0C3, 1'b0);
        chk("R4", {31'd0, rx_irq}, 32'd0);

        // R10 short glitch is rejected
        rx_in = 1'b0; idle(4 * TDIV); rx_in = 1'b1; idle(3 * BITC);
        chk("R10", {31'd0, rx_irq}, 32'd0);

        // R5 overrun on third word, third dropped
        d1 = 9'h011; d2 = 9'h022; d3 = 9'h033;
        send(d1, 1'b0, 1'b1);
        send(d2, 1'b0, 1'b1);
        chk("R5", {31'd0, overrun}, 32'd0);
        send(d3, 1'b0, 1'b1);
        chk("R5", {31'd0, overrun}, 32'd1);
        read_chk("R5", d1, 1'b0);
        read_chk("R5", d2, 1'b0);
        chk("R5", {31'd0, rx_irq}, 32'd0);
        send(9'h044, 1'b0, 1'b1);
        chk("R5", {31'd0, rx_irq}, 32'd0);
        chk("R5", {31'd0, overrun}, 32'd1);
        // R6 clear by dropping cont_rx; frames ignored while it is 0
        cont_rx = 1'b0; idle(3);
        chk("R6", {31'd0, overrun}, 32'd0);
        send(9'h066, 1'b0, 1'b1);
        chk("R6", {31'd0, rx_irq}, 32'd0);
        cont_rx = 1'b1;
        port_en = 1'b0;
        send(9'h067, 1'b0, 1'b1);
        chk("R6", {31'd0, rx_irq}, 32'd0);
        port_en = 1'b1;
        send(9'h077, 1'b0, 1'b1);
        read_chk("R6", 9'h077, 1'b0);

        // R7/R8/R9 wake-up on a break
        wake_set = 1'b1; @(negedge clk); wake_set = 1'b0; @(negedge clk);
        chk("R9", {31'd0, wake_en}, 32'd1);
        chk("R7", {31'd0, rx_irq}, 32'd0);
        rx_in = 1'b0; idle(2 * BITC);
        chk("R7", {31'd0, rx_irq}, 32'd1);
        chk("R9", {31'd0, wake_en}, 32'd1);
        idle(11 * BITC);
        rx_in = 1'b1; idle(6);
        chk("R9", {31'd0, wake_en}, 32'd0);
        chk("R8", {31'd0, rx_irq}, 32'd1);
        idle(2 * BITC);
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        chk("R8", {31'd0, rx_irq}, 32'd0);
        chk("R7", {31'd0, rx_irq}, 32'd0);
        send(9'h0E1, 1'b0, 1'b1);
        read_chk("R9", 9'h0E1, 1'b0);

        // Random frames: R1 R2 R3
        for (int k = 0; k < 24; k++) begin
            d1 = 9'($urandom);
            nb = 1'($urandom);
            sb = ($urandom % 4) != 0;
            nine_bit = nb;
            send(d1, nb, sb);
            read_chk(nb ? "R2" : "R1", exp_word(d1, nb), ~sb);
            chk("R3", {31'd0, rx_irq}, 32'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule